// File: doc/BRIEF.md
# Same-Index Routing Switch Box

This block sits at the crossing of a horizontal and a vertical routing channel in a programmable fabric. Every channel carries `TRACKS` wires, and the box has one input and one output per side (north, east, south, west) for each track. A wire arriving on one side can be joined to the wire with the same track number on any of the other three sides. A wire is never joined to a wire with a different track number. Wire segments span one logic block and end at a box like this one, so a longer path is built by chaining boxes.

Each track has six configuration bits, one for each unordered pair of sides. A set bit joins the two sides in both directions. In silicon this would be a pass switch. Here it is modelled with separate directed inputs and outputs: each output is the OR of the inputs from the other sides whose pair bit is set. The configuration is shifted in serially, one bit per clock while the load enable is high, and track 0 is loaded first. The outputs are combinational in the routing inputs and the stored configuration.

Top module: `sbox_disjoint`

## Requirements
- R1: While reset is low, and after it is released, every configuration bit is 0, so every output is 0 whatever the inputs are.
- R2: For each track k and side s, the output equals the OR of the track-k inputs of the other sides whose pair bit is set. If no such input exists, the output is 0.
- R3: Pair bits within a track's 6-bit field are: bit 0 north–east, bit 1 north–south, bit 2 north–west, bit 3 east–south, bit 4 east–west, bit 5 south–west.
- R4: An output of track k never depends on an input of any other track.
- R5: A single pair bit connects its two sides in both directions.
- R6: One bit is captured on each rising clock edge at which `cfg_load_en` is high. After 6·TRACKS such edges, the j-th bit shifted in (counting from 0) is pair bit j mod 6 of track j/6.
- R7: When `cfg_load_en` is low, the configuration holds, and toggling `cfg_bit` has no effect on any output.
- R8: Outputs follow input changes in the same cycle, with no clock edge between input and output.
- R9: A side's input never reaches that side's own output, even when all pair bits are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears the configuration |
| cfg_load_en | input | 1 | Shift-enable for the configuration chain |
| cfg_bit | input | 1 | Serial configuration data |
| north_in | input | TRACKS | Wires entering from the north side |
| east_in | input | TRACKS | Wires entering from the east side |
| south_in | input | TRACKS | Wires entering from the south side |
| west_in | input | TRACKS | Wires entering from the west side |
| north_out | output | TRACKS | Wires leaving to the north side |
| east_out | output | TRACKS | Wires leaving to the east side |
| south_out | output | TRACKS | Wires leaving to the south side |
| west_out | output | TRACKS | Wires leaving to the west side |

## Verification
The only state in the block is the configuration chain, so any corruption of it shows up at the outputs as soon as a routing input is driven. That corruption might be a bit lost during a shift, a shift when the enable is low, or a bit landing in the wrong track. The bench checks every pattern in the same cycle it is applied. It first sets single pair bits to expose bit-position and direction errors, then uses random configurations and inputs to expose crosstalk between tracks. Toggling `cfg_bit` with the enable low, followed by a fresh set of input patterns, exposes an unintended shift within one check.

// File: rtl/sbox_pkg.sv
package sbox_pkg;
    localparam int SIDES = 4;
    localparam int PAIRS = 6;

    // side encoding: 0 north, 1 east, 2 south, 3 west
    // pair index for two distinct sides a, b
    function automatic int pair_idx(input int a, input int b);
        int lo;
        int hi;
        lo = (a < b) ? a : b;
        hi = (a < b) ? b : a;
        if (lo == 0)      return hi - 1;
        else if (lo == 1) return hi + 1;
        else              return 5;
    endfunction
endpackage

// File: rtl/sbox_cfg_chain.sv
module sbox_cfg_chain #(
    parameter int NBITS = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic             bit_in,
    output logic [NBITS-1:0] cfg
);
    typedef struct packed {
        logic [NBITS-1:0] chain;
    } chain_t;

    chain_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_en) begin
            st_d.chain = {bit_in, st_q.chain[NBITS-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg = st_q.chain;
endmodule

// File: rtl/sbox_track_xbar.sv
module sbox_track_xbar
    import sbox_pkg::*;
(
    input  logic [SIDES-1:0] side_in,
    input  logic [PAIRS-1:0] pair_en,
    output logic [SIDES-1:0] side_out
);
    always_comb begin
        side_out = '0;
        for (int o = 0; o < SIDES; o++) begin
            for (int i = 0; i < SIDES; i++) begin
                if (i != o) begin
                    side_out[o] = side_out[o] | (side_in[i] & pair_en[pair_idx(o, i)]);
                end
            end
        end
    end
endmodule

// File: rtl/sbox_disjoint.sv
module sbox_disjoint
    import sbox_pkg::*;
#(
    parameter int TRACKS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_load_en,
    input  logic              cfg_bit,
    input  logic [TRACKS-1:0] north_in,
    input  logic [TRACKS-1:0] east_in,
    input  logic [TRACKS-1:0] south_in,
    input  logic [TRACKS-1:0] west_in,
    output logic [TRACKS-1:0] north_out,
    output logic [TRACKS-1:0] east_out,
    output logic [TRACKS-1:0] south_out,
    output logic [TRACKS-1:0] west_out
);
    localparam int CFG_BITS = PAIRS * TRACKS;

    logic [CFG_BITS-1:0] cfg_q;

    sbox_cfg_chain #(.NBITS(CFG_BITS)) i_chain (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (cfg_load_en),
        .bit_in  (cfg_bit),
        .cfg     (cfg_q)
    );

    for (genvar k = 0; k < TRACKS; k++) begin : g_track
        logic [SIDES-1:0] t_in;
        logic [SIDES-1:0] t_out;
        assign t_in = {west_in[k], south_in[k], east_in[k], north_in[k]};

        sbox_track_xbar i_xbar (
            .side_in  (t_in),
            .pair_en  (cfg_q[PAIRS*k +: PAIRS]),
            .side_out (t_out)
        );

        assign north_out[k] = t_out[0];
        assign east_out[k]  = t_out[1];
        assign south_out[k] = t_out[2];
        assign west_out[k]  = t_out[3];
    end
endmodule

// File: rtl/sbox_disjoint_chk.sv
module sbox_disjoint_chk #(
    parameter int TRACKS = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_load_en,
    input logic              cfg_bit,
    input logic [TRACKS-1:0] north_in,
    input logic [TRACKS-1:0] east_in,
    input logic [TRACKS-1:0] south_in,
    input logic [TRACKS-1:0] west_in,
    input logic [TRACKS-1:0] north_out,
    input logic [TRACKS-1:0] east_out,
    input logic [TRACKS-1:0] south_out,
    input logic [TRACKS-1:0] west_out
);
    logic [4*TRACKS-1:0] all_in;
    logic [4*TRACKS-1:0] all_out;
    assign all_in  = {west_in, south_in, east_in, north_in};
    assign all_out = {west_out, south_out, east_out, north_out};

    // R1: configuration is empty on the first edge after reset release
    a_r1_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (all_out == '0));

    // R2: with no input driven, nothing can appear at any output
    a_r2_quiet_inputs: assert property (@(posedge clk) disable iff (!rst_n)
        (all_in == '0) |-> (all_out == '0));

    // R7: with the load enable low, unchanged inputs give unchanged outputs
    a_r7_hold_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_load_en |=> (!$stable(all_in) || $stable(all_out)));

    // R4: a silent track stays silent whatever the other tracks carry
    for (genvar k = 0; k < TRACKS; k++) begin : g_iso
        a_r4_track_isolated: assert property (@(posedge clk) disable iff (!rst_n)
            ({north_in[k], east_in[k], south_in[k], west_in[k]} == 4'b0)
            |-> ({north_out[k], east_out[k], south_out[k], west_out[k]} == 4'b0));
    end

    logic unused_cfg_bit;
    assign unused_cfg_bit = cfg_bit;
endmodule

bind sbox_disjoint sbox_disjoint_chk #(.TRACKS(TRACKS)) i_sbox_disjoint_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_load_en (cfg_load_en),
    .cfg_bit     (cfg_bit),
    .north_in    (north_in),
    .east_in     (east_in),
    .south_in    (south_in),
    .west_in     (west_in),
    .north_out   (north_out),
    .east_out    (east_out),
    .south_out   (south_out),
    .west_out    (west_out)
);

// File: tb/test_sbox_disjoint.sv
module test_sbox_disjoint;
    localparam int W  = 4;
    localparam int NB = 6 * W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_load_en = 1'b0;
    logic cfg_bit = 1'b0;
    logic [3:0][W-1:0] tb_in = '0;
    logic [3:0][W-1:0] tb_out;

    always #4 clk = ~clk;

    sbox_disjoint #(.TRACKS(W)) i_sbox_disjoint (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_load_en (cfg_load_en),
        .cfg_bit     (cfg_bit),
        .north_in    (tb_in[0]),
        .east_in     (tb_in[1]),
        .south_in    (tb_in[2]),
        .west_in     (tb_in[3]),
        .north_out   (tb_out[0]),
        .east_out    (tb_out[1]),
        .south_out   (tb_out[2]),
        .west_out    (tb_out[3])
    );

    typedef struct {
        logic [3:0][W-1:0] exp;
        string             tag;
    } item_t;

    item_t q[$];
    logic [NB-1:0] model_cfg = '0;
    int n_tests = 0;
    int n_fail = 0;
    bit done = 0;

    // pair bit per R3, sides 0=N 1=E 2=S 3=W
    function automatic int bench_pair(input int a, input int b);
        case ({a[1:0], b[1:0]})
            4'b0001, 4'b0100: return 0;
            4'b0010, 4'b1000: return 1;
            4'b0011, 4'b1100: return 2;
            4'b0110, 4'b1001: return 3;
            4'b0111, 4'b1101: return 4;
            default:          return 5;
        endcase
    endfunction

    function automatic logic [3:0][W-1:0] predict(input logic [3:0][W-1:0] v);
        logic [3:0][W-1:0] r;
        r = '0;
        for (int k = 0; k < W; k++)
            for (int s = 0; s < 4; s++)
                for (int t = 0; t < 4; t++)
                    if (s != t && model_cfg[6*k + bench_pair(s, t)] && v[t][k])
                        r[s][k] = 1'b1;
        return r;
    endfunction

    task automatic apply(input logic [3:0][W-1:0] v, input string tag);
        item_t it;
        @(negedge clk);
        tb_in = v;
        it.exp = predict(v);
        it.tag = tag;
        q.push_back(it);
    endtask

    task automatic load_cfg(input logic [NB-1:0] bits);
        for (int j = 0; j < NB; j++) begin
            @(negedge clk);
            cfg_load_en = 1'b1;
            cfg_bit = bits[j];
        end
        @(negedge clk);
        cfg_load_en = 1'b0;
        model_cfg = bits;
    endtask

    // monitor: compares just after each falling edge, well before the rising edge
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                n_tests++;
                if (tb_out !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: got %h expected %h", it.tag, tb_out, it.exp);
                end
            end
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [NB-1:0] c;
        logic [3:0][W-1:0] v;
        // R1: in reset, all inputs high, nothing routed
        repeat (2) @(negedge clk);
        apply('1, "R1 in reset");
        @(negedge clk);
        rst_n = 1'b1;
        apply('1, "R1 after release");

        // R3 R5 R8: single pair bit on track 0, one side driven at a time
        for (int p = 0; p < 6; p++) begin
            c = '0;
            c[p] = 1'b1;
            load_cfg(c);
            for (int s = 0; s < 4; s++) begin
                v = '0;
                v[s][0] = 1'b1;
                apply(v, $sformatf("R3/R5/R8 pair %0d side %0d", p, s));
            end
        end

        // R6: a single bit deep in the stream lands at track 2 east-west
        c = '0;
        c[6*2 + 4] = 1'b1;
        load_cfg(c);
        v = '0; v[1][2] = 1'b1;
        apply(v, "R6 stream order east->west track 2");
        v = '0; v[3][2] = 1'b1;
        apply(v, "R6 stream order west->east track 2");

        // R9: every pair bit set, one side driven, own side stays low
        load_cfg('1);
        for (int k = 0; k < W; k++)
            for (int s = 0; s < 4; s++) begin
                v = '0;
                v[s][k] = 1'b1;
                apply(v, $sformatf("R9 no return track %0d side %0d", k, s));
            end

        // R7: toggle serial data with enable low, config must hold
        c = {NB/2{2'b10}};
        load_cfg(c);
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            cfg_bit = ~cfg_bit;
        end
        for (int i = 0; i < 8; i++) begin
            v = {$urandom, $urandom};
            apply(v, "R7 hold with load low");
        end

        // R2 R4: random configurations and inputs, plus single-track drive
        for (int n = 0; n < 30; n++) begin
            for (int j = 0; j < NB; j++) c[j] = 1'($urandom);
            load_cfg(c);
            for (int i = 0; i < 6; i++) begin
                v = {$urandom, $urandom};
                apply(v, "R2 random pattern");
            end
            for (int k = 0; k < W; k++) begin
                v = '0;
                for (int s = 0; s < 4; s++) v[s][k] = 1'b1;
                apply(v, $sformatf("R4 only track %0d driven", k));
            end
        end

        repeat (3) @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule